// File: doc/BRIEF.md
# Dual-Bucket Frame Relay Policer

This block decides, for every arriving Frame Relay frame, whether the frame is forwarded as is, forwarded with its discard-eligible (DE) bit raised, or dropped. Each of up to 16 connections owns two byte-counting leaky buckets. The committed bucket is sized by a committed burst and leaks at the committed rate. The excess bucket is sized by an excess burst and leaks at the excess rate.

No periodic refill is used. When a frame arrives, each bucket is drained by its rate times the number of timer ticks since that connection's last accepted frame. The elapsed time comes from a free-running counter supplied by the surrounding logic. Frames marked DE on entry are measured against the excess bucket only.

Rates, burst sizes, bucket levels and timestamps are held per connection in a small register array. Software-side logic loads each connection through a one-cycle configuration strobe. One verdict leaves the block two clock cycles after each arrival strobe.

Top module: `fr_dual_policer`

## Requirements
- R1: After reset no verdict is presented (out_valid low), and every connection has both rates at zero, both capacities at zero, both levels at zero and timestamp zero. Until it is configured, a connection therefore drops any frame of nonzero length and passes a zero-length frame.
- R2: A frame strobed on frm_valid yields exactly one verdict: out_valid is high for one cycle, two clock edges after the edge that samples the strobe. out_idx carries the connection index of that frame. Frames on consecutive cycles are each judged against the state left by the previous one.
- R3: A stored bucket level never exceeds that bucket's configured capacity.
- R4: Verdict codes are 0 = forward unchanged, 1 = forward with DE set, 2 = drop; code 3 never appears. A DE=0 frame that fits the committed bucket receives code 0, and its byte count is added to the committed bucket only.
- R5: A DE=0 frame that does not fit the committed bucket but fits the excess bucket receives code 1, and its byte count is added to the excess bucket only.
- R6: A DE=0 frame that fits neither bucket receives code 2. The connection's levels and timestamp stay unchanged.
- R7: A DE=1 frame is measured only against the excess bucket. It receives code 0 if it fits and code 2 otherwise, never code 1.
- R8: Rates are unsigned fixed point with 8 fractional bits, in bytes per timer tick. The drain of a bucket is floor(elapsed × rate / 256). A drain larger than the level leaves the level at zero.
- R9: The timestamp of a connection moves to the frame's time only when the frame is accepted (code 0 or 1). On acceptance both buckets keep their drained levels. After a drop, the elapsed time keeps growing from the last accepted frame.
- R10: The elapsed time is the frame time minus the stored timestamp, modulo 2^16, so a wrap of the time counter gives the short forward distance.
- R11: A configuration write loads both rates and both capacities of one connection, empties both of its buckets, and sets its timestamp to now_time.
- R12: A frame fits a bucket when the drained level plus the frame length is less than or equal to the capacity; one byte more does not fit.
- R13: Connections are independent: frames on one connection do not change the verdicts of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Connection being configured |
| cfg_cir | input | 16 | Committed rate, bytes per tick, 8 fractional bits |
| cfg_eir | input | 16 | Excess rate, bytes per tick, 8 fractional bits |
| cfg_bc | input | 22 | Committed bucket capacity in bytes |
| cfg_be | input | 22 | Excess bucket capacity in bytes |
| frm_valid | input | 1 | Frame arrival strobe |
| frm_idx | input | 4 | Connection of the arriving frame |
| frm_len | input | 16 | Frame length in bytes |
| frm_de | input | 1 | Incoming discard-eligible bit |
| now_time | input | 16 | Free-running time counter |
| out_valid | output | 1 | Verdict valid |
| out_idx | output | 4 | Connection of the verdict |
| out_verdict | output | 2 | 0 forward, 1 forward with DE set, 2 drop |

## Verification
On every cycle, the assertions check the two-cycle verdict timing and the echo of the connection index. They also check that a DE=1 frame is never marked and that a legal code is always produced. At each state write, they check that no bucket level exceeds its capacity. The arithmetic of the policer is left to the bench's scenarios. These cover the drain rounding, the exact fit boundary, the refusal to advance the timestamp after a drop, counter wraparound, the clearing effect of reconfiguration, and independence between connections.

// File: rtl/fr_pol_pkg.sv
package fr_pol_pkg;
  typedef enum logic [1:0] {
    VERD_PASS = 2'd0,
    VERD_MARK = 2'd1,
    VERD_DROP = 2'd2
  } verdict_e;

  localparam int NUM_BKT = 2;
  localparam int BKT_CMT = 0;
  localparam int BKT_EXC = 1;
endpackage

// File: rtl/fr_pol_bucket.sv
// One leaky bucket: drain by elapsed*rate, then test the frame against capacity.
module fr_pol_bucket #(
  parameter int TIME_W    = 16,
  parameter int RATE_W    = 16,
  parameter int RATE_FRAC = 8,
  parameter int BKT_W     = 22,
  parameter int LEN_W     = 16
) (
  input  logic [TIME_W-1:0] elapsed_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [BKT_W-1:0]  level_i,
  input  logic [BKT_W-1:0]  cap_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BKT_W-1:0]  drained_o,
  output logic              fits_o
);
  localparam int CALC_W = TIME_W + RATE_W;

  logic [CALC_W-1:0] prod;
  logic [CALC_W-1:0] drain;
  logic [CALC_W-1:0] sum;

  always_comb begin
    prod  = CALC_W'(elapsed_i) * CALC_W'(rate_i);
    drain = prod >> RATE_FRAC;
    if (drain >= CALC_W'(level_i)) begin
      drained_o = '0;
    end else begin
      drained_o = level_i - drain[BKT_W-1:0];
    end
    sum    = CALC_W'(drained_o) + CALC_W'(len_i);
    fits_o = (sum <= CALC_W'(cap_i));
  end
endmodule

// File: rtl/fr_pol_ctx_store.sv
// Per-connection rates, capacities, levels and timestamp.
module fr_pol_ctx_store #(
  parameter int N_CONN = 16,
  parameter int IDX_W  = 4,
  parameter int TIME_W = 16,
  parameter int RATE_W = 16,
  parameter int BKT_W  = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [1:0][RATE_W-1:0] cfg_rate,
  input  logic [1:0][BKT_W-1:0]  cfg_cap,
  input  logic [TIME_W-1:0]      cfg_time,
  input  logic                   upd_en,
  input  logic [IDX_W-1:0]       upd_idx,
  input  logic [1:0][BKT_W-1:0]  upd_level,
  input  logic [TIME_W-1:0]      upd_time,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [1:0][RATE_W-1:0] rd_rate,
  output logic [1:0][BKT_W-1:0]  rd_cap,
  output logic [1:0][BKT_W-1:0]  rd_level,
  output logic [TIME_W-1:0]      rd_time
);
  logic [1:0][RATE_W-1:0] rate_q  [N_CONN];
  logic [1:0][RATE_W-1:0] rate_d  [N_CONN];
  logic [1:0][BKT_W-1:0]  cap_q   [N_CONN];
  logic [1:0][BKT_W-1:0]  cap_d   [N_CONN];
  logic [1:0][BKT_W-1:0]  level_q [N_CONN];
  logic [1:0][BKT_W-1:0]  level_d [N_CONN];
  logic [TIME_W-1:0]      time_q  [N_CONN];
  logic [TIME_W-1:0]      time_d  [N_CONN];

  // next state: frame update first, configuration overrides it
  always_comb begin
    rate_d  = rate_q;
    cap_d   = cap_q;
    level_d = level_q;
    time_d  = time_q;
    if (upd_en) begin
      level_d[upd_idx] = upd_level;
      time_d[upd_idx]  = upd_time;
    end
    if (cfg_we) begin
      rate_d[cfg_idx]  = cfg_rate;
      cap_d[cfg_idx]   = cfg_cap;
      level_d[cfg_idx] = '0;
      time_d[cfg_idx]  = cfg_time;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CONN; i++) begin
        rate_q[i]  <= '0;
        cap_q[i]   <= '0;
        level_q[i] <= '0;
        time_q[i]  <= '0;
      end
    end else begin
      rate_q  <= rate_d;
      cap_q   <= cap_d;
      level_q <= level_d;
      time_q  <= time_d;
    end
  end

  assign rd_rate  = rate_q[rd_idx];
  assign rd_cap   = cap_q[rd_idx];
  assign rd_level = level_q[rd_idx];
  assign rd_time  = time_q[rd_idx];
endmodule

// File: rtl/fr_pol_decide.sv
// Verdict selection and new bucket levels.
module fr_pol_decide
  import fr_pol_pkg::*;
#(
  parameter int BKT_W = 22,
  parameter int LEN_W = 16
) (
  input  logic                  de_i,
  input  logic [1:0]            fits_i,
  input  logic [1:0][BKT_W-1:0] drained_i,
  input  logic [LEN_W-1:0]      len_i,
  output verdict_e              verdict_o,
  output logic                  accept_o,
  output logic [1:0][BKT_W-1:0] level_o
);
  always_comb begin
    level_o   = drained_i;
    accept_o  = 1'b0;
    verdict_o = VERD_DROP;
    if (!de_i && fits_i[BKT_CMT]) begin
      verdict_o        = VERD_PASS;
      accept_o         = 1'b1;
      level_o[BKT_CMT] = drained_i[BKT_CMT] + BKT_W'(len_i);
    end else if (fits_i[BKT_EXC]) begin
      verdict_o        = de_i ? VERD_PASS : VERD_MARK;
      accept_o         = 1'b1;
      level_o[BKT_EXC] = drained_i[BKT_EXC] + BKT_W'(len_i);
    end
  end
endmodule

// File: rtl/fr_dual_policer.sv
module fr_dual_policer
  import fr_pol_pkg::*;
#(
  parameter int  N_CONN    = 16,
  parameter int  TIME_W    = 16,
  parameter int  LEN_W     = 16,
  parameter int  RATE_W    = 16,
  parameter int  RATE_FRAC = 8,
  parameter int  BKT_W     = 22,
  localparam int IDX_W     = $clog2(N_CONN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [RATE_W-1:0] cfg_cir,
  input  logic [RATE_W-1:0] cfg_eir,
  input  logic [BKT_W-1:0]  cfg_bc,
  input  logic [BKT_W-1:0]  cfg_be,
  input  logic              frm_valid,
  input  logic [IDX_W-1:0]  frm_idx,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              frm_de,
  input  logic [TIME_W-1:0] now_time,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [1:0]        out_verdict
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // stage 1: capture the arrival
  logic              s1_vld_q, s1_vld_d;
  logic [IDX_W-1:0]  s1_idx_q, s1_idx_d;
  logic [LEN_W-1:0]  s1_len_q, s1_len_d;
  logic              s1_de_q, s1_de_d;
  logic [TIME_W-1:0] s1_time_q, s1_time_d;

  always_comb begin
    s1_vld_d  = frm_valid;
    s1_idx_d  = s1_idx_q;
    s1_len_d  = s1_len_q;
    s1_de_d   = s1_de_q;
    s1_time_d = s1_time_q;
    if (frm_valid) begin
      s1_idx_d  = frm_idx;
      s1_len_d  = frm_len;
      s1_de_d   = frm_de;
      s1_time_d = now_time;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      s1_vld_q  <= 1'b0;
      s1_idx_q  <= '0;
      s1_len_q  <= '0;
      s1_de_q   <= 1'b0;
      s1_time_q <= '0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_idx_q  <= s1_idx_d;
      s1_len_q  <= s1_len_d;
      s1_de_q   <= s1_de_d;
      s1_time_q <= s1_time_d;
    end
  end

  // stage 2: read context, evaluate both buckets, write back
  logic [1:0][RATE_W-1:0] rd_rate;
  logic [1:0][BKT_W-1:0]  rd_cap;
  logic [1:0][BKT_W-1:0]  rd_level;
  logic [TIME_W-1:0]      rd_time;
  logic [TIME_W-1:0]      elapsed;
  logic [1:0][BKT_W-1:0]  drained;
  logic [1:0]             fits;
  verdict_e               verdict;
  logic                   accept;
  logic                   upd_en;
  logic [1:0][BKT_W-1:0]  upd_level;

  assign elapsed = s1_time_q - rd_time;
  assign upd_en  = s1_vld_q & accept;

  fr_pol_ctx_store #(
    .N_CONN(N_CONN), .IDX_W(IDX_W), .TIME_W(TIME_W),
    .RATE_W(RATE_W), .BKT_W(BKT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_rate  ({cfg_eir, cfg_cir}),
    .cfg_cap   ({cfg_be, cfg_bc}),
    .cfg_time  (now_time),
    .upd_en    (upd_en),
    .upd_idx   (s1_idx_q),
    .upd_level (upd_level),
    .upd_time  (s1_time_q),
    .rd_idx    (s1_idx_q),
    .rd_rate   (rd_rate),
    .rd_cap    (rd_cap),
    .rd_level  (rd_level),
    .rd_time   (rd_time)
  );

  for (genvar b = 0; b < NUM_BKT; b++) begin : g_bkt
    fr_pol_bucket #(
      .TIME_W(TIME_W), .RATE_W(RATE_W), .RATE_FRAC(RATE_FRAC),
      .BKT_W(BKT_W), .LEN_W(LEN_W)
    ) u_bkt (
      .elapsed_i (elapsed),
      .rate_i    (rd_rate[b]),
      .level_i   (rd_level[b]),
      .cap_i     (rd_cap[b]),
      .len_i     (s1_len_q),
      .drained_o (drained[b]),
      .fits_o    (fits[b])
    );
  end

  fr_pol_decide #(.BKT_W(BKT_W), .LEN_W(LEN_W)) u_decide (
    .de_i      (s1_de_q),
    .fits_i    (fits),
    .drained_i (drained),
    .len_i     (s1_len_q),
    .verdict_o (verdict),
    .accept_o  (accept),
    .level_o   (upd_level)
  );

  // output register
  logic             out_vld_q, out_vld_d;
  logic [IDX_W-1:0] out_idx_q, out_idx_d;
  logic [1:0]       out_verd_q, out_verd_d;

  always_comb begin
    out_vld_d  = s1_vld_q;
    out_idx_d  = out_idx_q;
    out_verd_d = out_verd_q;
    if (s1_vld_q) begin
      out_idx_d  = s1_idx_q;
      out_verd_d = verdict;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_vld_q  <= 1'b0;
      out_idx_q  <= '0;
      out_verd_q <= VERD_PASS;
    end else begin
      out_vld_q  <= out_vld_d;
      out_idx_q  <= out_idx_d;
      out_verd_q <= out_verd_d;
    end
  end

  assign out_valid   = out_vld_q;
  assign out_idx     = out_idx_q;
  assign out_verdict = out_verd_q;
endmodule

// File: rtl/fr_dual_policer_chk.sv
module fr_dual_policer_chk #(
  parameter int IDX_W = 4,
  parameter int BKT_W = 22
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frm_valid,
  input logic [IDX_W-1:0]      frm_idx,
  input logic                  frm_de,
  input logic                  out_valid,
  input logic [IDX_W-1:0]      out_idx,
  input logic [1:0]            out_verdict,
  input logic                  upd_en,
  input logic [1:0][BKT_W-1:0] upd_level,
  input logic [1:0][BKT_W-1:0] rd_cap
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ##2 out_valid);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |-> ##2 !out_valid);

  assert_idx_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ##2 (out_idx == $past(frm_idx, 2)));

  assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_verdict != 2'd3));

  assert_de_no_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_de) |-> ##2 (out_verdict != 2'd1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ((upd_level[0] <= rd_cap[0]) && (upd_level[1] <= rd_cap[1])));
endmodule

bind fr_dual_policer fr_dual_policer_chk #(.IDX_W(IDX_W), .BKT_W(BKT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .frm_valid   (frm_valid),
  .frm_idx     (frm_idx),
  .frm_de      (frm_de),
  .out_valid   (out_valid),
  .out_idx     (out_idx),
  .out_verdict (out_verdict),
  .upd_en      (upd_en),
  .upd_level   (upd_level),
  .rd_cap      (rd_cap)
);

// File: tb/fr_dual_policer_tb.sv
module fr_dual_policer_tb;
  localparam logic [1:0] PASS = 2'd0;
  localparam logic [1:0] MARK = 2'd1;
  localparam logic [1:0] DROP = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_cir = '0;
  logic [15:0] cfg_eir = '0;
  logic [21:0] cfg_bc = '0;
  logic [21:0] cfg_be = '0;
  logic        frm_valid = 1'b0;
  logic [3:0]  frm_idx = '0;
  logic [15:0] frm_len = '0;
  logic        frm_de = 1'b0;
  logic [15:0] now_time = '0;
  logic        out_valid;
  logic [3:0]  out_idx;
  logic [1:0]  out_verdict;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  fr_dual_policer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_cir(cfg_cir), .cfg_eir(cfg_eir),
    .cfg_bc(cfg_bc), .cfg_be(cfg_be),
    .frm_valid(frm_valid), .frm_idx(frm_idx), .frm_len(frm_len),
    .frm_de(frm_de), .now_time(now_time),
    .out_valid(out_valid), .out_idx(out_idx), .out_verdict(out_verdict)
  );

  typedef struct packed {
    logic [3:0]  idx;
    logic [15:0] len;
    logic        de;
    logic [15:0] t;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 15;
  // conn 3: cir 1 B/tick, eir 2 B/tick, bc 1000, be 500 (cfg at t=0)
  // conn 5: cir 0.5 B/tick, eir 0, bc 100, be 0 (cfg at t=0)
  // conn 7: cir 1 B/tick, eir 0, bc 10, be 0 (cfg at t=65530)
  localparam vec_t VECS [NV] = '{
    '{4'd3, 16'd600,   1'b0, 16'd0,     PASS},  // R4 fits committed
    '{4'd3, 16'd400,   1'b0, 16'd0,     PASS},  // R12 exact fit at 1000
    '{4'd3, 16'd1,     1'b0, 16'd0,     MARK},  // R12 R5 R3 one over, into excess
    '{4'd3, 16'd500,   1'b0, 16'd0,     DROP},  // R6 fits neither
    '{4'd3, 16'd499,   1'b1, 16'd0,     PASS},  // R7 DE=1 fits excess
    '{4'd3, 16'd1,     1'b1, 16'd0,     DROP},  // R7 DE=1 over excess
    '{4'd3, 16'd100,   1'b0, 16'd100,   PASS},  // R8 drain 100 committed
    '{4'd3, 16'd200,   1'b1, 16'd100,   PASS},  // R9 excess drained on accept
    '{4'd3, 16'd60,    1'b0, 16'd150,   MARK},  // R8 both drains
    '{4'd5, 16'd100,   1'b0, 16'd150,   PASS},  // R13 other connection
    '{4'd5, 16'd1,     1'b0, 16'd151,   DROP},  // R8 floor of half byte
    '{4'd5, 16'd1,     1'b0, 16'd152,   PASS},  // R9 elapsed from last accept
    '{4'd7, 16'd10,    1'b0, 16'd65530, PASS},  // R10 setup
    '{4'd7, 16'd9,     1'b0, 16'd2,     DROP},  // R10 wrapped elapsed 8
    '{4'd7, 16'd8,     1'b0, 16'd2,     PASS}   // R10 fits after wrap
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [15:0] cir, input logic [15:0] eir,
                     input logic [21:0] bc, input logic [21:0] be, input logic [15:0] t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_cir = cir; cfg_eir = eir;
    cfg_bc = bc; cfg_be = be; now_time = t;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [3:0] idx, input logic [15:0] len, input logic de,
                      input logic [15:0] t, input logic [1:0] exp, input string what);
    @(negedge clk);
    frm_valid = 1'b1; frm_idx = idx; frm_len = len; frm_de = de; now_time = t;
    @(negedge clk);
    frm_valid = 1'b0;
    check({what, " R2 not early"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    check({what, " R2 valid"}, 32'(out_valid), 32'd1);
    check({what, " verdict"}, 32'(out_verdict), 32'(exp));
    check({what, " R2 idx"}, 32'(out_idx), 32'(idx));
    @(negedge clk);
    check({what, " R2 single pulse"}, 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);

    // R1: unconfigured connection has zero capacities
    send(4'd0, 16'd1, 1'b0, 16'd0, DROP, "R1 unconfigured len1");
    send(4'd0, 16'd0, 1'b0, 16'd0, PASS, "R1 unconfigured len0");

    cfg(4'd3, 16'd256, 16'd512, 22'd1000, 22'd500, 16'd0);
    cfg(4'd5, 16'd128, 16'd0,   22'd100,  22'd0,   16'd0);
    cfg(4'd7, 16'd256, 16'd0,   22'd10,   22'd0,   16'd65530);

    for (int k = 0; k < NV; k++) begin
      send(VECS[k].idx, VECS[k].len, VECS[k].de, VECS[k].t, VECS[k].exp,
           $sformatf("vector %0d", k));
    end

    // R11: reconfiguration empties buckets and restamps
    cfg(4'd3, 16'd256, 16'd512, 22'd1000, 22'd500, 16'd200);
    send(4'd3, 16'd1000, 1'b0, 16'd200, PASS, "R11 cleared by cfg");

    // R2: back-to-back frames on one connection see each other's update
    @(negedge clk);
    frm_valid = 1'b1; frm_idx = 4'd5; frm_len = 16'd100; frm_de = 1'b0; now_time = 16'd400;
    @(negedge clk);
    frm_len = 16'd1;
    @(negedge clk);
    frm_valid = 1'b0;
    check("R2 b2b first valid", 32'(out_valid), 32'd1);
    check("R2 b2b first verdict", 32'(out_verdict), 32'(PASS));
    @(negedge clk);
    check("R2 b2b second valid", 32'(out_valid), 32'd1);
    check("R2 b2b second verdict", 32'(out_verdict), 32'(DROP));
    @(negedge clk);
    check("R2 b2b idle", 32'(out_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule